// File: doc/BRIEF.md
# Shifter Operand Generator with Carry

This combinational block forms the second operand of a 32-bit data-processing ALU and the carry that a flag-setting move or logical operation writes back. The operand comes from one of two sources. The first is a small constant: an 8-bit byte rotated right by an even amount taken from a 4-bit code. The second is a register value sent through a shifter that supports logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The shift count is either a 5-bit field from the instruction or the low byte of a second register.

The carry produced alongside the operand is the last bit shifted out. Where no bit leaves the word, the incoming carry flag passes through unchanged. An invert control presents the bitwise complement of the operand for move-negated operations and leaves the carry as it is. Flag storage, the ALU, condition checks and instruction decode live elsewhere. The block connects between the register file read ports and the ALU B input.

Top module: `shifter_operand_gen`

## Requirements
- R1: With `use_imm`=1 and `imm_rot`=0, `operand` is `imm_byte` zero-extended to 32 bits, `carry_out` equals `carry_in`, and all register-path inputs have no effect.
- R2: With `use_imm`=1 and `imm_rot`=k≠0, `operand` is the zero-extended byte rotated right by 2·k bit positions, and `carry_out` is bit 31 of that rotated value.
- R3: `shift_kind` encodes 0=logical left, 1=logical right, 2=arithmetic right, 3=rotate right. A logical left by an instruction count of 0 passes `reg_val` through unchanged, with `carry_out`=`carry_in`.
- R4: For a logical left by n, counts 1..31 give `reg_val`<<n with carry `reg_val[32-n]`. A count of 32 gives 0 with carry `reg_val[0]`. A count above 32 gives 0 with carry 0.
- R5: For a logical right by n, counts 1..31 give `reg_val`>>n with carry `reg_val[n-1]`. A count of 32 (including instruction count 0, which means 32) gives 0 with carry `reg_val[31]`. A count above 32 gives 0 with carry 0.
- R6: For an arithmetic right by n, counts 1..31 give the sign-filled shift with carry `reg_val[n-1]`. A count of 32 or more (including instruction count 0) gives 32 copies of `reg_val[31]` with carry `reg_val[31]`.
- R7: For a rotate right with a register count n≠0, the rotation is n mod 32. When n mod 32 is 0, `operand`=`reg_val` and the carry is `reg_val[31]`. Otherwise the carry is bit 31 of the rotated result.
- R8: Rotate right with an instruction count of 0 selects the extended rotate: `operand`={`carry_in`, `reg_val[31:1]`} and `carry_out`=`reg_val[0]`.
- R9: With `amt_from_reg`=1 and `amt_reg`=0, every shift kind passes `reg_val` unchanged with `carry_out`=`carry_in`, and `amt_imm` has no effect.
- R10: With `invert`=1, `operand` is the bitwise complement of the value it would otherwise have, and `carry_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm | input | 1 | Select the rotated-constant source instead of the register shifter |
| imm_byte | input | 8 | Constant byte |
| imm_rot | input | 4 | Rotate code; the byte rotates right by twice this value |
| reg_val | input | 32 | Register value to shift |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg | input | 1 | Take the shift count from `amt_reg` instead of `amt_imm` |
| amt_imm | input | 5 | Shift count from the instruction field |
| amt_reg | input | 8 | Shift count from the low byte of a register |
| carry_in | input | 1 | Current carry flag |
| invert | input | 1 | Complement the operand for move-negated |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry for flag update |

## Verification
The hardest cases are the count boundaries, because the same count value means different things depending on its source. An instruction count of 0 stands for 32 in the right shifts, for "no shift" in the left shift and for the extended rotate in the rotate kind. A register count of 32, 33 or a multiple of 32 each takes a different carry path. The stimulus drives both count sources at these exact values and chooses register patterns in which the expected carry bit differs from its neighbours and from `carry_in`, so that an off-by-one in bit selection changes the result.

// File: rtl/sog_pkg.sv
package sog_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/sog_amount_decode.sv
// Resolves the effective shift count and the extended-rotate selection.
module sog_amount_decode
  import sog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int AMT_W  = 8
) (
  input  shift_kind_e      kind,
  input  logic             from_reg,
  input  logic [SH_W-1:0]  amt_imm,
  input  logic [AMT_W-1:0] amt_reg,
  output logic [AMT_W-1:0] eff_amt,
  output logic             rrx_sel
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  always_comb begin
    eff_amt = '0;
    rrx_sel = 1'b0;
    if (from_reg) begin
      eff_amt = amt_reg;
    end else if (amt_imm != '0) begin
      eff_amt = AMT_W'(amt_imm);
    end else begin
      unique case (kind)
        SK_LSL:         eff_amt = '0;
        SK_LSR, SK_ASR: eff_amt = FULL_AMT;
        SK_ROR:         rrx_sel = 1'b1;
        default:        eff_amt = '0;
      endcase
    end
  end
endmodule

// File: rtl/sog_barrel.sv
// Register shifter with carry extraction.
module sog_barrel
  import sog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx_sel,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [DATA_W:0]        lsl_ext;
  logic [DATA_W:0]        lsr_ext;
  logic signed [DATA_W:0] asr_src;
  logic signed [DATA_W:0] asr_ext;
  logic [SH_W-1:0]        ror_amt;
  logic [SH_W:0]          ror_back;
  logic [DATA_W-1:0]      ror_val;

  always_comb begin
    lsl_ext  = {1'b0, value} << amt;
    lsr_ext  = {value, 1'b0} >> amt;
    asr_src  = {value, 1'b0};
    asr_ext  = asr_src >>> amt;
    ror_amt  = amt[SH_W-1:0];
    ror_back = (SH_W+1)'(DATA_W) - {1'b0, ror_amt};
    ror_val  = (value >> ror_amt) | (value << ror_back);
  end

  always_comb begin
    result    = value;
    carry_out = carry_in;
    if (rrx_sel) begin
      result    = {carry_in, value[DATA_W-1:1]};
      carry_out = value[0];
    end else if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          result    = lsl_ext[DATA_W-1:0];
          carry_out = lsl_ext[DATA_W];
        end
        SK_LSR: begin
          result    = lsr_ext[DATA_W:1];
          carry_out = lsr_ext[0];
        end
        SK_ASR: begin
          result    = asr_ext[DATA_W:1];
          carry_out = asr_ext[0];
        end
        SK_ROR: begin
          result    = ror_val;
          carry_out = ror_val[DATA_W-1];
        end
        default: begin
          result    = value;
          carry_out = carry_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/sog_imm_rotator.sv
// Builds the rotated-constant operand.
module sog_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [DATA_W-1:0] base;
  logic [SH_W-1:0]   amt;
  logic [SH_W:0]     back;

  always_comb begin
    base      = DATA_W'(imm_byte);
    amt       = SH_W'({imm_rot, 1'b0});
    back      = (SH_W+1)'(DATA_W) - {1'b0, amt};
    result    = (base >> amt) | (base << back);
    carry_out = (imm_rot == '0) ? carry_in : result[DATA_W-1];
  end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import sog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [1:0]        shift_kind,
  input  logic              amt_from_reg,
  input  logic [SH_W-1:0]   amt_imm,
  input  logic [AMT_W-1:0]  amt_reg,
  input  logic              carry_in,
  input  logic              invert,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out
);
  shift_kind_e       kind;
  logic [AMT_W-1:0]  eff_amt;
  logic              rrx_sel;
  logic [DATA_W-1:0] sh_val;
  logic              sh_carry;
  logic [DATA_W-1:0] imm_val;
  logic              imm_carry;
  logic [DATA_W-1:0] pre_inv;

  assign kind = shift_kind_e'(shift_kind);

  sog_amount_decode #(.DATA_W(DATA_W), .SH_W(SH_W), .AMT_W(AMT_W)) u_dec (
    .kind     (kind),
    .from_reg (amt_from_reg),
    .amt_imm  (amt_imm),
    .amt_reg  (amt_reg),
    .eff_amt  (eff_amt),
    .rrx_sel  (rrx_sel)
  );

  sog_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .AMT_W(AMT_W)) u_bar (
    .value     (reg_val),
    .kind      (kind),
    .amt       (eff_amt),
    .rrx_sel   (rrx_sel),
    .carry_in  (carry_in),
    .result    (sh_val),
    .carry_out (sh_carry)
  );

  sog_imm_rotator #(.DATA_W(DATA_W), .SH_W(SH_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_byte  (imm_byte),
    .imm_rot   (imm_rot),
    .carry_in  (carry_in),
    .result    (imm_val),
    .carry_out (imm_carry)
  );

  always_comb begin
    pre_inv   = use_imm ? imm_val : sh_val;
    carry_out = use_imm ? imm_carry : sh_carry;
    operand   = invert ? ~pre_inv : pre_inv;
  end
endmodule

// File: rtl/sog_checker.sv
module sog_checker #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input logic              use_imm,
  input logic [IMM_W-1:0]  imm_byte,
  input logic [ROT_W-1:0]  imm_rot,
  input logic [DATA_W-1:0] reg_val,
  input logic [1:0]        shift_kind,
  input logic              amt_from_reg,
  input logic [SH_W-1:0]   amt_imm,
  input logic [AMT_W-1:0]  amt_reg,
  input logic              carry_in,
  input logic              invert,
  input logic [DATA_W-1:0] operand,
  input logic              carry_out
);
  logic [DATA_W-1:0] plain;
  logic              known;

  always_comb begin
    plain = operand ^ {DATA_W{invert}};
    known = !$isunknown({use_imm, imm_byte, imm_rot, reg_val, shift_kind,
                         amt_from_reg, amt_imm, amt_reg, carry_in, invert,
                         operand, carry_out});
    if (known) begin
      if (use_imm && imm_rot == '0)
        p_imm_plain_r1: assert (plain == DATA_W'(imm_byte) && carry_out == carry_in)
          else $error("imm rotate-0 mismatch");
      if (use_imm && imm_rot != '0)
        p_imm_carry_r2: assert (carry_out == plain[DATA_W-1])
          else $error("imm rotate carry mismatch");
      if (!use_imm && amt_from_reg && amt_reg == '0)
        p_zero_count_r9: assert (plain == reg_val && carry_out == carry_in)
          else $error("zero register count mismatch");
      if (!use_imm && amt_from_reg && shift_kind == 2'd0 && amt_reg > AMT_W'(DATA_W))
        p_lsl_far_r4: assert (plain == '0 && !carry_out)
          else $error("far left shift mismatch");
      if (!use_imm && amt_from_reg && shift_kind == 2'd2 && amt_reg >= AMT_W'(DATA_W))
        p_asr_far_r6: assert (plain == {DATA_W{reg_val[DATA_W-1]}} && carry_out == reg_val[DATA_W-1])
          else $error("far arithmetic shift mismatch");
      if (!use_imm && !amt_from_reg && shift_kind == 2'd3 && amt_imm == '0)
        p_rrx_r8: assert (plain[DATA_W-1] == carry_in && carry_out == reg_val[0])
          else $error("extended rotate mismatch");
    end
  end
endmodule

bind shifter_operand_gen sog_checker #(
  .DATA_W(DATA_W), .SH_W(SH_W), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
  .use_imm      (use_imm),
  .imm_byte     (imm_byte),
  .imm_rot      (imm_rot),
  .reg_val      (reg_val),
  .shift_kind   (shift_kind),
  .amt_from_reg (amt_from_reg),
  .amt_imm      (amt_imm),
  .amt_reg      (amt_reg),
  .carry_in     (carry_in),
  .invert       (invert),
  .operand      (operand),
  .carry_out    (carry_out)
);

// File: tb/tb_shifter_operand_gen.sv
module tb_shifter_operand_gen;
  logic        clk;
  logic        rst_n;
  logic        use_imm;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [31:0] reg_val;
  logic [1:0]  shift_kind;
  logic        amt_from_reg;
  logic [4:0]  amt_imm;
  logic [7:0]  amt_reg;
  logic        carry_in;
  logic        invert;
  logic [31:0] operand;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  shifter_operand_gen dut (
    .use_imm      (use_imm),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .reg_val      (reg_val),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .carry_in     (carry_in),
    .invert       (invert),
    .operand      (operand),
    .carry_out    (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] exp_op, input logic exp_c);
    checks++;
    if (operand !== exp_op || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
               req, operand, carry_out, exp_op, exp_c);
    end
  endtask

  task automatic drive_imm(input logic [7:0] b, input logic [3:0] r, input logic cin,
                           input logic inv, input logic [31:0] junk);
    @(negedge clk);
    use_imm = 1'b1; imm_byte = b; imm_rot = r; carry_in = cin; invert = inv;
    reg_val = junk; shift_kind = 2'd1; amt_from_reg = 1'b1; amt_reg = 8'd3; amt_imm = 5'd7;
    #1;
  endtask

  task automatic drive_reg(input logic [31:0] v, input logic [1:0] k, input logic from_reg,
                           input logic [4:0] ai, input logic [7:0] ar, input logic cin,
                           input logic inv);
    @(negedge clk);
    use_imm = 1'b0; imm_byte = 8'h5A; imm_rot = 4'd3; reg_val = v; shift_kind = k;
    amt_from_reg = from_reg; amt_imm = ai; amt_reg = ar; carry_in = cin; invert = inv;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    use_imm = 1'b0; imm_byte = '0; imm_rot = '0; reg_val = '0; shift_kind = 2'd0;
    amt_from_reg = 1'b0; amt_imm = '0; amt_reg = '0; carry_in = 1'b0; invert = 1'b0;
    #1;
    check("R3 idle state", 32'h0, 1'b0);
  endtask

  task automatic t_imm_plain;
    drive_imm(8'hA5, 4'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check("R1 byte cin=1", 32'h0000_00A5, 1'b1);
    drive_imm(8'hA5, 4'd0, 1'b0, 1'b0, 32'h1234_5678);
    check("R1 byte cin=0", 32'h0000_00A5, 1'b0);
  endtask

  task automatic t_imm_rot;
    drive_imm(8'hFF, 4'd4, 1'b0, 1'b0, 32'h0);
    check("R2 rot 8", 32'hFF00_0000, 1'b1);
    drive_imm(8'h01, 4'd1, 1'b1, 1'b0, 32'h0);
    check("R2 rot 2 carry 0", 32'h4000_0000, 1'b0);
    drive_imm(8'h03, 4'd1, 1'b0, 1'b0, 32'h0);
    check("R2 rot 2 carry 1", 32'hC000_0000, 1'b1);
  endtask

  task automatic t_pass;
    drive_reg(32'h1234_5678, 2'd0, 1'b0, 5'd0, 8'd9, 1'b1, 1'b0);
    check("R3 unshifted", 32'h1234_5678, 1'b1);
  endtask

  task automatic t_lsl;
    drive_reg(32'hF000_000F, 2'd0, 1'b0, 5'd4, 8'd0, 1'b0, 1'b0);
    check("R4 lsl 4", 32'h0000_00F0, 1'b1);
    drive_reg(32'h8000_0000, 2'd0, 1'b1, 5'd0, 8'd1, 1'b0, 1'b0);
    check("R4 lsl reg 1", 32'h0, 1'b1);
    drive_reg(32'h0000_0001, 2'd0, 1'b1, 5'd0, 8'd32, 1'b0, 1'b0);
    check("R4 lsl reg 32", 32'h0, 1'b1);
    drive_reg(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd33, 1'b1, 1'b0);
    check("R4 lsl reg 33", 32'h0, 1'b0);
  endtask

  task automatic t_lsr;
    drive_reg(32'h0000_00F8, 2'd1, 1'b0, 5'd4, 8'd0, 1'b0, 1'b0);
    check("R5 lsr 4", 32'h0000_000F, 1'b1);
    drive_reg(32'h8000_0000, 2'd1, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0);
    check("R5 lsr imm 0 means 32", 32'h0, 1'b1);
    drive_reg(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd40, 1'b1, 1'b0);
    check("R5 lsr reg 40", 32'h0, 1'b0);
    drive_reg(32'h0000_0002, 2'd1, 1'b1, 5'd0, 8'd1, 1'b1, 1'b0);
    check("R5 lsr reg 1", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_asr;
    drive_reg(32'h8000_0000, 2'd2, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0);
    check("R6 asr imm 0 means 32", 32'hFFFF_FFFF, 1'b1);
    drive_reg(32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 8'd200, 1'b1, 1'b0);
    check("R6 asr reg 200", 32'h0, 1'b0);
    drive_reg(32'h8000_0010, 2'd2, 1'b0, 5'd4, 8'd0, 1'b1, 1'b0);
    check("R6 asr 4", 32'hF800_0001, 1'b0);
    drive_reg(32'h8000_0010, 2'd2, 1'b0, 5'd5, 8'd0, 1'b0, 1'b0);
    check("R6 asr 5", 32'hFC00_0000, 1'b1);
  endtask

  task automatic t_ror;
    drive_reg(32'h1234_5678, 2'd3, 1'b0, 5'd8, 8'd0, 1'b1, 1'b0);
    check("R7 ror 8", 32'h7812_3456, 1'b0);
    drive_reg(32'h0000_000F, 2'd3, 1'b1, 5'd0, 8'd36, 1'b0, 1'b0);
    check("R7 ror reg 36", 32'hF000_0000, 1'b1);
    drive_reg(32'h8000_0000, 2'd3, 1'b1, 5'd0, 8'd32, 1'b0, 1'b0);
    check("R7 ror reg 32", 32'h8000_0000, 1'b1);
    drive_reg(32'h0000_0001, 2'd3, 1'b1, 5'd0, 8'd64, 1'b1, 1'b0);
    check("R7 ror reg 64", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_rrx;
    drive_reg(32'h0000_0003, 2'd3, 1'b0, 5'd0, 8'd5, 1'b1, 1'b0);
    check("R8 rrx cin=1", 32'h8000_0001, 1'b1);
    drive_reg(32'h0000_0002, 2'd3, 1'b0, 5'd0, 8'd5, 1'b0, 1'b0);
    check("R8 rrx cin=0", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_zero_reg;
    for (int k = 0; k < 4; k++) begin
      drive_reg(32'h8000_0001, 2'(k), 1'b1, 5'd5, 8'd0, 1'b1, 1'b0);
      check("R9 reg count 0", 32'h8000_0001, 1'b1);
    end
  endtask

  task automatic t_invert;
    drive_imm(8'hA5, 4'd0, 1'b1, 1'b1, 32'h0);
    check("R10 invert imm", 32'hFFFF_FF5A, 1'b1);
    drive_reg(32'h8000_0000, 2'd0, 1'b1, 5'd0, 8'd1, 1'b0, 1'b1);
    check("R10 invert lsl", 32'hFFFF_FFFF, 1'b1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_imm_plain();
    t_imm_rot();
    t_pass();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rrx();
    t_zero_reg();
    t_invert();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule